// File: doc/BRIEF.md
# End-of-Interrupt and Deactivate Unit

This unit serves the two completion writes that a virtual interrupt interface accepts from a guest: the end-of-interrupt write and the separate deactivate write. It owns the list of interrupt entries, each of which describes one virtual interrupt with its ID, priority, group, active and pending state, and an optional link to a physical interrupt. An end-of-interrupt write always asks an external active-priority tracker to drop its highest active priority, and the unit keeps the value that the tracker reports. When the split mode input is clear, the same write also retires the matching active entry. When split mode is set, that work moves to the deactivate write.

To retire an entry, the unit finds the lowest-indexed entry among the first `used_cnt` entries whose virtual ID equals the request ID and whose active bit is set. An end-of-interrupt retires it only if the group of the request equals the group of the entry and the preemption value of the entry equals the dropped priority. A mismatch is ignored without any trace. A retired entry loses its active bit. If the entry is linked to a physical interrupt, its physical ID leaves on a one-cycle deactivate pulse. When no entry matches, a 5-bit miss counter in a 32-bit control word is incremented. IDs at or above the first message-based interrupt ID never retire anything.

The control is one state machine with five states. ST_IDLE accepts a request. It moves to ST_DROP for an end-of-interrupt, to ST_FIND for a deactivate write that can retire an entry, and to ST_DONE for any other deactivate write. ST_DROP holds the drop request until the tracker acknowledges. It then moves to ST_FIND when retirement is possible, and to ST_DONE otherwise. ST_FIND registers the search result and always moves to ST_APPLY. ST_APPLY retires the entry or counts the miss and always moves to ST_DONE. ST_DONE signals completion for one cycle and returns to ST_IDLE.

Top module: `eoi_deact_unit`

## Requirements
- R1: Each accepted end-of-interrupt raises `drop_req` and holds it until a cycle with `drop_ack` high, which ends it. The unit stores `drop_prio` from that cycle as the dropped priority. An accepted deactivate write never raises `drop_req`.
- R2: A request whose ID is at or above `LPI_BASE` (8192 by default) retires no entry, produces no deactivate pulse and leaves the miss counter unchanged.
- R3: With `eoi_split` = 1, an end-of-interrupt only drops priority. With `eoi_split` = 0, a deactivate write has no effect on the entries, the counter or the pulse output.
- R4: The search selects the lowest index below `used_cnt` whose entry has virtual ID bits [31:0] equal to the request ID and active bit [62] set. Entries at or above `used_cnt` are never selected.
- R5: When the search finds no entry, the miss counter in control-word bits [31:27] increases by one and wraps from 31 to 0. The other control bits keep their values.
- R6: An end-of-interrupt retires the found entry only if `req_grp` equals group bit [60] of the entry and the preemption value of the entry equals the dropped priority. Otherwise nothing changes. A deactivate write in split mode retires the found entry without either check.
- R7: Retiring an entry clears only its active bit [62]. If hardware-link bit [61] is set, `pdeact_valid` is high for exactly one cycle and carries physical ID bits [41:32].
- R8: The preemption value is priority bits [55:48] with the low B bits cleared. For group 0, B = `bpr0`+1. For group 1 with `cbpr` = 1, B = min(`bpr0`+1, 7). For group 1 with `cbpr` = 0, B = `bpr1`.
- R9: `req_ready` is high only in ST_IDLE. `done` is high for one cycle per request, and entry and control updates are visible in that cycle.
- R10: After reset the control word is 0, every entry is 0, and `drop_req`, `pdeact_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Completion write offered |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_dir | input | 1 | 1 = deactivate write, 0 = end-of-interrupt |
| req_id | input | 32 | Virtual interrupt ID written by the guest |
| req_grp | input | 1 | Group of the requesting register |
| eoi_split | input | 1 | Split mode: priority drop and deactivation separated |
| bpr0 | input | 3 | Group 0 binary point |
| bpr1 | input | 3 | Group 1 binary point |
| cbpr | input | 1 | Group 1 uses the group 0 binary point |
| used_cnt | input | IDX_W+1 | Number of entries in use |
| drop_req | output | 1 | Request to the tracker to drop its highest active priority |
| drop_ack | input | 1 | Tracker has dropped a priority |
| drop_prio | input | 8 | Priority dropped by the tracker |
| done | output | 1 | Request complete |
| lr_wr_en | input | 1 | Load one entry |
| lr_wr_idx | input | IDX_W | Entry to load |
| lr_wr_data | input | 64 | Entry value |
| lr_rd_idx | input | IDX_W | Entry to read back |
| lr_rd_data | output | 64 | Entry value read back |
| ctl_wr_en | input | 1 | Load the control word |
| ctl_wr_data | input | 32 | Control word value |
| ctl_q | output | 32 | Control word with the miss counter |
| pdeact_valid | output | 1 | Physical deactivate pulse |
| pdeact_id | output | 10 | Physical interrupt ID to deactivate |

## Verification
The assertions assume that the tracker raises `drop_ack` only while `drop_req` is high. They also assume that entry and control loads never coincide with an ST_APPLY cycle, and that the mode and binary-point inputs stay stable while a request is in flight. The stimulus loads entries and the control word only between requests, while `req_ready` is high. It changes the mode inputs only at those points, and it holds `drop_ack` high so that every priority drop takes exactly one cycle.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
    localparam int VID_W   = 32;
    localparam int PID_W   = 10;
    localparam int PRIO_W  = 8;
    localparam int CTL_W   = 32;
    localparam int CNT_LSB = 27;
    localparam int CNT_W   = 5;

    typedef struct packed {
        logic              pend;
        logic              act;
        logic              hw;
        logic              grp;
        logic [3:0]        spare_hi;
        logic [PRIO_W-1:0] prio;
        logic [5:0]        spare_lo;
        logic [PID_W-1:0]  pid;
        logic [VID_W-1:0]  vid;
    } lr_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DROP,
        ST_FIND,
        ST_APPLY,
        ST_DONE
    } eoi_state_e;
endpackage

// File: rtl/eoi_lr_file.sv
module eoi_lr_file
    import eoi_pkg::*;
#(
    parameter int NUM_LR = 8,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  lr_entry_t               wr_data,
    input  logic                    clr_en,
    input  logic [IDX_W-1:0]        clr_idx,
    input  logic [IDX_W-1:0]        rd_idx,
    output lr_entry_t               rd_data,
    output lr_entry_t [NUM_LR-1:0]  entries
);
    lr_entry_t mem_q [NUM_LR];

    for (genvar g = 0; g < NUM_LR; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (clr_en && (clr_idx == IDX_W'(g))) begin
                mem_q[g].act <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem_q[g] <= wr_data;
            end
        end
        assign entries[g] = mem_q[g];
    end

    assign rd_data = mem_q[rd_idx];

    // R7: a retirement touches only the active bit of the chosen entry
    p_clear_only_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (!mem_q[$past(clr_idx)].act &&
                    mem_q[$past(clr_idx)].vid == $past(mem_q[clr_idx].vid) &&
                    mem_q[$past(clr_idx)].pid == $past(mem_q[clr_idx].pid)));
endmodule

// File: rtl/eoi_match_find.sv
module eoi_match_find
    import eoi_pkg::*;
#(
    parameter int NUM_LR = 8,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  lr_entry_t [NUM_LR-1:0] entries,
    input  logic [IDX_W:0]         used_cnt,
    input  logic [VID_W-1:0]       id,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx
);
    logic [NUM_LR-1:0] cand;

    for (genvar g = 0; g < NUM_LR; g++) begin : g_cmp
        assign cand[g] = (($bits(used_cnt)+1)'(g) < {1'b0, used_cnt}) &&
                         entries[g].act && (entries[g].vid == id);
    end

    always_comb begin
        hit = |cand;
        idx = '0;
        for (int k = NUM_LR - 1; k >= 0; k--) begin
            if (cand[k]) idx = IDX_W'(k);
        end
    end
endmodule

// File: rtl/eoi_preempt.sv
module eoi_preempt
    import eoi_pkg::*;
(
    input  logic [PRIO_W-1:0] prio,
    input  logic              grp,
    input  logic [2:0]        bpr0,
    input  logic [2:0]        bpr1,
    input  logic              cbpr,
    output logic [PRIO_W-1:0] pre
);
    logic [3:0] shift;

    always_comb begin
        if (!grp) begin
            shift = {1'b0, bpr0} + 4'd1;
        end else if (cbpr) begin
            shift = (bpr0 < 3'd7) ? ({1'b0, bpr0} + 4'd1) : 4'd7;
        end else begin
            shift = {1'b0, bpr1};
        end
        pre = prio & (PRIO_W'({PRIO_W{1'b1}}) << shift);
    end
endmodule

// File: rtl/eoi_deact_unit.sv
module eoi_deact_unit
    import eoi_pkg::*;
#(
    parameter int NUM_LR   = 8,
    parameter int LPI_BASE = 8192,
    localparam int IDX_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_dir,
    input  logic [31:0]        req_id,
    input  logic               req_grp,
    input  logic               eoi_split,
    input  logic [2:0]         bpr0,
    input  logic [2:0]         bpr1,
    input  logic               cbpr,
    input  logic [IDX_W:0]     used_cnt,
    output logic               drop_req,
    input  logic               drop_ack,
    input  logic [7:0]         drop_prio,
    output logic               done,
    input  logic               lr_wr_en,
    input  logic [IDX_W-1:0]   lr_wr_idx,
    input  logic [63:0]        lr_wr_data,
    input  logic [IDX_W-1:0]   lr_rd_idx,
    output logic [63:0]        lr_rd_data,
    input  logic               ctl_wr_en,
    input  logic [31:0]        ctl_wr_data,
    output logic [31:0]        ctl_q,
    output logic               pdeact_valid,
    output logic [9:0]         pdeact_id
);
    eoi_state_e state_q, state_d;

    logic              dir_q, grp_q, split_q, lpi_q;
    logic [VID_W-1:0]  id_q;
    logic [PRIO_W-1:0] dropped_q;
    logic              hit_q;
    logic [IDX_W-1:0]  idx_q;
    lr_entry_t         entry_q;

    lr_entry_t [NUM_LR-1:0] entries;
    lr_entry_t              rd_ent;
    logic                   find_hit;
    logic [IDX_W-1:0]       find_idx;
    logic [PRIO_W-1:0]      ent_pre;
    logic                   do_deact, clr_en, req_lpi, accept;
    logic [CTL_W-1:0]       ctl_r;

    assign req_lpi = (req_id >= 32'(LPI_BASE));
    assign accept  = req_valid && (state_q == ST_IDLE);

    eoi_lr_file #(.NUM_LR(NUM_LR)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lr_wr_en),
        .wr_idx  (lr_wr_idx),
        .wr_data (lr_entry_t'(lr_wr_data)),
        .clr_en  (clr_en),
        .clr_idx (idx_q),
        .rd_idx  (lr_rd_idx),
        .rd_data (rd_ent),
        .entries (entries)
    );

    eoi_match_find #(.NUM_LR(NUM_LR)) u_find (
        .entries  (entries),
        .used_cnt (used_cnt),
        .id       (id_q),
        .hit      (find_hit),
        .idx      (find_idx)
    );

    eoi_preempt u_pre (
        .prio (entry_q.prio),
        .grp  (entry_q.grp),
        .bpr0 (bpr0),
        .bpr1 (bpr1),
        .cbpr (cbpr),
        .pre  (ent_pre)
    );

    assign lr_rd_data = rd_ent;
    assign ctl_q      = ctl_r;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_dir)                     state_d = ST_DROP;
                    else if (eoi_split && !req_lpi)   state_d = ST_FIND;
                    else                              state_d = ST_DONE;
                end
            end
            ST_DROP: begin
                if (drop_ack) state_d = (!split_q && !lpi_q) ? ST_FIND : ST_DONE;
            end
            ST_FIND:  state_d = ST_APPLY;
            ST_APPLY: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // retirement decision in ST_APPLY
    always_comb begin
        do_deact = 1'b0;
        if (hit_q) begin
            if (dir_q) do_deact = 1'b1;
            else       do_deact = (grp_q == entry_q.grp) && (ent_pre == dropped_q);
        end
    end
    assign clr_en = (state_q == ST_APPLY) && do_deact;

    // request capture and search registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= 1'b0;
            grp_q     <= 1'b0;
            split_q   <= 1'b0;
            lpi_q     <= 1'b0;
            id_q      <= '0;
            dropped_q <= '1;
            hit_q     <= 1'b0;
            idx_q     <= '0;
            entry_q   <= '0;
        end else begin
            if (accept) begin
                dir_q   <= req_dir;
                grp_q   <= req_grp;
                split_q <= eoi_split;
                lpi_q   <= req_lpi;
                id_q    <= req_id;
            end
            if ((state_q == ST_DROP) && drop_ack) dropped_q <= drop_prio;
            if (state_q == ST_FIND) begin
                hit_q   <= find_hit;
                idx_q   <= find_idx;
                entry_q <= entries[find_idx];
            end
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_r        <= '0;
            pdeact_valid <= 1'b0;
            pdeact_id    <= '0;
        end else begin
            pdeact_valid <= clr_en && entry_q.hw;
            if (clr_en) pdeact_id <= entry_q.pid;
            if ((state_q == ST_APPLY) && !hit_q) begin
                ctl_r[CNT_LSB +: CNT_W] <= ctl_r[CNT_LSB +: CNT_W] + CNT_W'(1);
            end else if (ctl_wr_en) begin
                ctl_r <= ctl_wr_data;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign drop_req  = (state_q == ST_DROP);
    assign done      = (state_q == ST_DONE);

    // R1: a drop request stays up until the tracker answers
    p_drop_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_req && !drop_ack) |=> drop_req);

    // R1: a deactivate write never leads to a drop request
    p_dir_no_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_dir) |=> !drop_req);

    // R5: the miss counter moves only by one step, apart from control loads
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctl_wr_en) && (ctl_q[CNT_LSB +: CNT_W] != $past(ctl_q[CNT_LSB +: CNT_W])))
        |-> (ctl_q[CNT_LSB +: CNT_W] == CNT_W'($past(ctl_q[CNT_LSB +: CNT_W]) + 1)));

    // R7: the physical deactivate is a single-cycle pulse
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pdeact_valid |=> !pdeact_valid);

    // R9: an accepted request leaves the idle state at once
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: completion lasts one cycle and is followed by readiness
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
endmodule

// File: tb/tb_eoi_deact_unit.sv
module tb_eoi_deact_unit;
    localparam int NUM_LR = 8;
    localparam int IDX_W  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_dir = 1'b0, req_grp = 1'b0;
    logic [31:0] req_id = '0;
    logic        eoi_split = 1'b0, cbpr = 1'b0;
    logic [2:0]  bpr0 = 3'd2, bpr1 = 3'd3;
    logic [IDX_W:0] used_cnt = 4'd8;
    logic        drop_req, drop_ack = 1'b1, done;
    logic [7:0]  drop_prio = 8'hFF;
    logic        lr_wr_en = 1'b0;
    logic [IDX_W-1:0] lr_wr_idx = '0, lr_rd_idx = '0;
    logic [63:0] lr_wr_data = '0, lr_rd_data;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0, ctl_q;
    logic        pdeact_valid;
    logic [9:0]  pdeact_id;

    always #2 clk = ~clk;  // 250 MHz

    eoi_deact_unit #(.NUM_LR(NUM_LR)) dut (.*);

    int checks = 0, errors = 0, drops_seen = 0;
    int exp_pid_q[$];
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected physical IDs as pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (drop_req) drops_seen++;
            if (pdeact_valid) begin
                if (exp_pid_q.size() == 0) chk(1'b0, "R7 unexpected pulse", pdeact_id, 0);
                else begin
                    int e;
                    e = exp_pid_q.pop_front();
                    chk(pdeact_id == 10'(e), "R7 physical id", pdeact_id, e);
                end
            end
        end
    end

    task automatic put_entry(input int idx, input int vid, input int pid, input int prio,
                             input bit grp, input bit hw, input bit act);
        @(negedge clk);
        lr_wr_en   = 1'b1;
        lr_wr_idx  = IDX_W'(idx);
        lr_wr_data = {1'b0, act, hw, grp, 4'h0, 8'(prio), 6'h0, 10'(pid), 32'(vid)};
        @(negedge clk);
        lr_wr_en = 1'b0;
    endtask

    function automatic logic [4:0] cnt_now();
        return ctl_q[31:27];
    endfunction

    // driver: issues a request, pushes expectations, checks results at done
    task automatic issue(input bit dir, input int id, input bit grp, input int dprio,
                         input int exp_pid, input int cnt_inc, input int chk_idx,
                         input bit exp_act, input string tag);
        logic [4:0] cnt0;
        int d0, wd;
        cnt0 = cnt_now();
        d0   = drops_seen;
        if (exp_pid >= 0) exp_pid_q.push_back(exp_pid);
        @(negedge clk);
        req_valid = 1'b1; req_dir = dir; req_id = 32'(id); req_grp = grp;
        drop_prio = 8'(dprio);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R9 busy after accept"}, req_ready, 0);
        wd = 0;
        while (!done && wd < 50) begin @(negedge clk); wd++; end
        chk(done == 1'b1, {tag, " R9 done seen"}, done, 1);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R9 ready again"}, req_ready, 1);
        chk(exp_pid_q.size() == 0, {tag, " R7 pulse count"}, exp_pid_q.size(), 0);
        exp_pid_q.delete();
        chk((drops_seen - d0) == (dir ? 0 : 1), {tag, " R1 drop requests"},
            drops_seen - d0, dir ? 0 : 1);
        chk(cnt_now() == 5'(cnt0 + 5'(cnt_inc)), {tag, " R5 miss count"},
            cnt_now(), 5'(cnt0 + 5'(cnt_inc)));
        if (chk_idx >= 0) begin
            lr_rd_idx = IDX_W'(chk_idx);
            #1;
            chk(lr_rd_data[62] == exp_act, {tag, " R7 active bit"}, lr_rd_data[62], exp_act);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ctl_q == 32'h0, "R10 control word", ctl_q, 0);
        chk(pdeact_valid == 1'b0 && done == 1'b0 && drop_req == 1'b0, "R10 outputs low",
            {pdeact_valid, done, drop_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        lr_rd_idx = 3'd5; #1;
        chk(lr_rd_data == 64'h0, "R10 entry cleared", lr_rd_data, 0);
        chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);

        // entries: 0 and 2 share vid 40, entry 1 vid 41
        put_entry(0, 40, 'h155, 'h48, 1'b1, 1'b1, 1'b1);
        put_entry(1, 41, 'h0, 'h50, 1'b1, 1'b0, 1'b1);
        put_entry(2, 40, 'h2AA, 'h48, 1'b1, 1'b1, 1'b1);

        // R6/R7/R8: matched EOI retires entry 0 (pre of 0x48, bpr1=3 -> 0x48)
        issue(0, 40, 1, 'h48, 'h155, 0, 0, 1'b0, "R6 eoi match");
        lr_rd_idx = 3'd0; #1;
        chk(lr_rd_data[31:0] == 32'd40 && lr_rd_data[41:32] == 10'h155,
            "R7 other fields kept", lr_rd_data[41:0], {10'h155, 32'd40});
        // R4: first active match is now entry 2
        issue(0, 40, 1, 'h48, 'h2AA, 0, 2, 1'b0, "R4 next match");
        // R5: miss
        issue(0, 40, 1, 'h48, -1, 1, -1, 1'b0, "R5 miss");
        // R6: group mismatch ignored
        issue(0, 41, 0, 'h50, -1, 0, 1, 1'b1, "R6 group mismatch");
        // R6: priority mismatch ignored
        issue(0, 41, 1, 'h40, -1, 0, 1, 1'b1, "R6 priority mismatch");
        // R8: subpriority bits cleared (0x57 -> 0x50 with bpr1=3), no hw link
        put_entry(1, 41, 'h0, 'h57, 1'b1, 1'b0, 1'b1);
        issue(0, 41, 1, 'h50, -1, 0, 1, 1'b0, "R8 group1 preemption");
        // R2: LPI range
        put_entry(3, 8192, 'h3, 'h10, 1'b1, 1'b1, 1'b1);
        issue(0, 8192, 1, 'h10, -1, 0, 3, 1'b1, "R2 eoi lpi");
        // R3: split mode
        eoi_split = 1'b1;
        put_entry(0, 40, 'h155, 'h48, 1'b1, 1'b1, 1'b1);
        issue(0, 40, 1, 'h48, -1, 0, 0, 1'b1, "R3 split eoi drop only");
        issue(1, 40, 0, 0, 'h155, 0, 0, 1'b0, "R3 split deactivate");
        issue(1, 99, 0, 0, -1, 1, -1, 1'b0, "R5 deactivate miss");
        issue(1, 8192, 1, 0, -1, 0, 3, 1'b1, "R2 deactivate lpi");
        eoi_split = 1'b0;
        put_entry(0, 40, 'h155, 'h48, 1'b1, 1'b1, 1'b1);
        issue(1, 40, 1, 0, -1, 0, 0, 1'b1, "R3 deactivate without split");
        // R8: group 0 uses bpr0+1 (0x4C -> 0x48)
        put_entry(1, 50, 'h11, 'h4C, 1'b0, 1'b1, 1'b1);
        issue(0, 50, 0, 'h48, 'h11, 0, 1, 1'b0, "R8 group0 preemption");
        // R8: group 1 with cbpr, bpr0=5 -> shift 6 (0x7F -> 0x40)
        cbpr = 1'b1; bpr0 = 3'd5;
        put_entry(4, 70, 'h22, 'h7F, 1'b1, 1'b1, 1'b1);
        issue(0, 70, 1, 'h40, 'h22, 0, 4, 1'b0, "R8 common binary point");
        cbpr = 1'b0; bpr0 = 3'd2;
        // R4: entries at or above used_cnt are not searched
        used_cnt = 4'd2;
        put_entry(5, 60, 'h33, 'h20, 1'b1, 1'b1, 1'b1);
        issue(0, 60, 1, 'h20, -1, 1, 5, 1'b1, "R4 beyond used count");
        used_cnt = 4'd8;
        // R5: wrap from 31 to 0, other bits kept
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = {5'd31, 27'h5A};
        @(negedge clk);
        ctl_wr_en = 1'b0;
        issue(0, 77, 1, 'h20, -1, 1, -1, 1'b0, "R5 wrap");
        chk(ctl_q == {5'd0, 27'h5A}, "R5 wrapped word", ctl_q, {5'd0, 27'h5A});

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule